// File: doc/BRIEF.md
# Multi-Driver Net Strength Resolver

This block settles the state of one shared net that up to `N` sources drive at the same time. Each source reports a four-valued logic value and a three-bit strength rank. The block combines all sources into one value and one strength for the net. The higher rank dominates. A tie between opposing values yields an unknown at that rank. The capacitive ranks sit in the same ordering as the driving ranks, just below them.

The sources are reduced through a balanced binary tree of identical pairwise combiners. This is correct because the combining rule is associative and commutative. The result is captured in one output register with a synchronous active-low reset. A model of a wired net, a pull-up with open-drain devices, or a charge-holding node can feed its source list in and read the settled net state one clock later.

Top module: `drv_resolver`

## Requirements
- R1: Each driver value is 2 bits, coded 00 = logic 0, 01 = logic 1, 10 = unknown (x), 11 = high impedance (z). Each driver strength is 3 bits and is ranked numerically: 7 supply, 6 strong, 5 pull, 4 weak, 3 large, 2 medium, 1 small, 0 undriven. Driving ranks (7..4) and capacitive ranks (3..1) compare on this one scale.
- R2: The resolved value and strength appear on the outputs one clock edge after the drivers are applied. At an edge with `rst_n` low, the outputs become z at strength 0.
- R3: When drivers disagree, the driver of highest strength sets both the net value and the net strength.
- R4: Two drivers of equal strength with opposite values (0 against 1) give x at that strength, provided no stronger driver exists.
- R5: Drivers that agree on a value give that value at the highest of their strengths.
- R6: When every driver is undriven, the net is z at strength 0. Strength 0 is reported only together with value z.
- R7: A driver at strength 0 is ignored whatever value it reports, and a driver reporting z is ignored whatever strength it reports.
- R8: A driving-rank source beats a capacitive-rank source only when its rank is strictly higher (weak 4 beats large 3). Equal ranks with opposite values give x.
- R9: A driver reporting x at strength s forces the net to x at s whenever s is at least the strength of every other active driver. A strictly stronger 0 or 1 driver overrides it.
- R10: The result does not depend on which driver slot a source occupies. It equals a one-by-one sequential reduction of the drivers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_val | input | 2*N | Driver values, driver i in bits [2i+1:2i] |
| drv_str | input | 3*N | Driver strengths, driver i in bits [3i+2:3i] |
| res_val | output | 2 | Resolved net value |
| res_str | output | 3 | Resolved net strength |

## Verification
The bench targets ties at the top rank: 0 against 1, and x against a known value. A design that compared with a strict inequality in the wrong place would let one slot win instead of producing x. It also pairs a weak source with a large capacitive node, both equal and one rank apart. An off-by-one in the rank scale shows up there as a wrong winner. Undriven slots that report 0 or 1, and slots that report z at supply strength, catch a combiner that lets an inactive source leak into the result. Random driver sets applied in forward and reversed slot order expose any non-associative tree stage, because the bench reduces them sequentially on its own.

// File: rtl/drvres_pkg.sv
// Package: shared encodings for the net strength resolver.
// Assumes the 2-bit value code 0/1/x/z and a 3-bit numeric strength rank.
package drvres_pkg;

    localparam int VAL_W = 2;
    localparam int STR_W = 3;

    localparam logic [VAL_W-1:0] LV_0 = 2'b00;
    localparam logic [VAL_W-1:0] LV_1 = 2'b01;
    localparam logic [VAL_W-1:0] LV_X = 2'b10;
    localparam logic [VAL_W-1:0] LV_Z = 2'b11;

    localparam logic [STR_W-1:0] STR_NONE = 3'd0;

    typedef struct packed {
        logic [VAL_W-1:0] val;
        logic [STR_W-1:0] str;
    } net_t;

    localparam net_t NET_FLOAT = '{val: LV_Z, str: STR_NONE};

endpackage

// File: rtl/drv_leaf.sv
// Module: drv_leaf
// Turns one raw driver into a canonical tree leaf. Inactive sources
// (strength 0 or value z) become the floating net, so later stages
// never see them. Purely combinational.
module drv_leaf
    import drvres_pkg::*;
(
    input  logic [VAL_W-1:0] in_val,
    input  logic [STR_W-1:0] in_str,
    output net_t             leaf
);

    // Collapse inactive sources to z at rank 0.
    always_comb begin
        if (in_str == STR_NONE || in_val == LV_Z) begin
            leaf = NET_FLOAT;
        end else begin
            leaf.val = in_val;
            leaf.str = in_str;
        end
    end

endmodule

// File: rtl/drv_pair.sv
// Module: drv_pair
// Merges two canonical net states into one. Higher rank wins outright;
// equal ranks keep an agreed value or turn into x at that rank.
// Assumes both inputs are canonical (rank 0 only with value z).
module drv_pair
    import drvres_pkg::*;
(
    input  net_t a,
    input  net_t b,
    output net_t y
);

    // Pick the stronger side, or merge on a tie.
    always_comb begin
        if (a.str > b.str) begin
            y = a;
        end else if (b.str > a.str) begin
            y = b;
        end else if (a.val == b.val) begin
            y = a;
        end else begin
            y.val = LV_X;
            y.str = a.str;
        end
    end

endmodule

// File: rtl/drv_resolver.sv
// Module: drv_resolver (top)
// Resolves N drivers on one net through a balanced tree of drv_pair
// stages, then registers the result. Unused tree leaves (N not a power
// of two) are tied to the floating net. Reset is synchronous, active low.
module drv_resolver
    import drvres_pkg::*;
#(
    parameter int N = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VAL_W*N-1:0] drv_val,
    input  logic [STR_W*N-1:0] drv_str,
    output logic [VAL_W-1:0]   res_val,
    output logic [STR_W-1:0]   res_str
);

    localparam int DEPTH  = (N > 1) ? $clog2(N) : 0;
    localparam int LEAVES = 1 << DEPTH;

    // Heap-ordered tree: node k has children 2k and 2k+1, leaves at LEAVES..2*LEAVES-1.
    net_t node [1:2*LEAVES-1];

    genvar j;
    generate
        for (j = 0; j < LEAVES; j++) begin : g_leaf
            if (j < N) begin : g_used
                drv_leaf u_leaf (
                    .in_val (drv_val[VAL_W*j +: VAL_W]),
                    .in_str (drv_str[STR_W*j +: STR_W]),
                    .leaf   (node[LEAVES+j])
                );
            end else begin : g_pad
                assign node[LEAVES+j] = NET_FLOAT;
            end
        end
        for (j = 1; j < LEAVES; j++) begin : g_node
            drv_pair u_pair (
                .a (node[2*j]),
                .b (node[2*j+1]),
                .y (node[j])
            );
        end
    endgenerate

    // Output register: capture the root, or float on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_val <= LV_Z;
            res_str <= STR_NONE;
        end else begin
            res_val <= node[1].val;
            res_str <= node[1].str;
        end
    end

endmodule

// File: rtl/drvres_chk.sv
// Module: drvres_chk
// Property checker for drv_resolver. Works out the top active rank and
// which values appear at that rank straight from the ports, then checks
// the registered outputs one edge later. Bound into every drv_resolver.
module drvres_chk
    import drvres_pkg::*;
#(
    parameter int N = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VAL_W*N-1:0] drv_val,
    input logic [STR_W*N-1:0] drv_str,
    input logic [VAL_W-1:0]   res_val,
    input logic [STR_W-1:0]   res_str
);

    logic [STR_W-1:0] top_str;
    logic             top_has0, top_has1, top_hasx;

    // Scan the port-level drivers for the top rank and the values present there.
    always_comb begin
        top_str  = STR_NONE;
        top_has0 = 1'b0;
        top_has1 = 1'b0;
        top_hasx = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (drv_str[STR_W*i +: STR_W] != STR_NONE && drv_val[VAL_W*i +: VAL_W] != LV_Z &&
                drv_str[STR_W*i +: STR_W] > top_str)
                top_str = drv_str[STR_W*i +: STR_W];
        end
        for (int i = 0; i < N; i++) begin
            if (top_str != STR_NONE && drv_str[STR_W*i +: STR_W] == top_str) begin
                if (drv_val[VAL_W*i +: VAL_W] == LV_0) top_has0 = 1'b1;
                if (drv_val[VAL_W*i +: VAL_W] == LV_1) top_has1 = 1'b1;
                if (drv_val[VAL_W*i +: VAL_W] == LV_X) top_hasx = 1'b1;
            end
        end
    end

    AST_RESET_FLOATS: assert property (@(posedge clk)
        !rst_n |=> (res_val == LV_Z && res_str == STR_NONE)); // R2

    AST_STRENGTH_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (res_str == $past(top_str))); // R3

    AST_ZERO_RANK_IS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (res_str == STR_NONE) == (res_val == LV_Z)); // R6

    AST_TIE_GIVES_X: assert property (@(posedge clk) disable iff (!rst_n)
        (top_has0 && top_has1) |=> (res_val == LV_X)); // R4

    AST_X_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        top_hasx |=> (res_val == LV_X)); // R9

    AST_AGREED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (top_has1 && !top_has0 && !top_hasx) |=> (res_val == LV_1)); // R5

    AST_NO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (top_str == STR_NONE) |=> (res_val == LV_Z)); // R7

endmodule

bind drv_resolver drvres_chk #(.N(N)) u_drvres_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .drv_val (drv_val),
    .drv_str (drv_str),
    .res_val (res_val),
    .res_str (res_str)
);

// File: tb/test_drv_resolver.sv
// Bench for drv_resolver: one task per scenario, each checking its own
// results against values derived from the requirements.
module test_drv_resolver;

    localparam int N = 8;
    localparam logic [1:0] V0 = 2'b00, V1 = 2'b01, VX = 2'b10, VZ = 2'b11;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] drv_val;
    logic [3*N-1:0] drv_str;
    logic [1:0]     res_val;
    logic [2:0]     res_str;

    logic [1:0] sv [N];
    logic [2:0] ss [N];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    drv_resolver #(.N(N)) i_drv_resolver (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_val (drv_val),
        .drv_str (drv_str),
        .res_val (res_val),
        .res_str (res_str)
    );

    // Independent sequential reference: fold one driver at a time.
    function automatic logic [4:0] ref_fold();
        logic [1:0] av = VZ;
        logic [2:0] as = 3'd0;
        for (int i = 0; i < N; i++) begin
            if (ss[i] != 3'd0 && sv[i] != VZ) begin
                if (ss[i] > as) begin
                    av = sv[i]; as = ss[i];
                end else if (ss[i] == as && sv[i] != av) begin
                    av = VX;
                end
            end
        end
        return {av, as};
    endfunction

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            sv[i] = VZ; ss[i] = 3'd0;
        end
    endtask

    task automatic apply();
        for (int i = 0; i < N; i++) begin
            drv_val[2*i +: 2] = sv[i];
            drv_str[3*i +: 3] = ss[i];
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [1:0] ev, logic [2:0] es);
        checks++;
        if (res_val !== ev || res_str !== es) begin
            errors++;
            $display("FAIL %s: got val=%b str=%0d, expected val=%b str=%0d",
                     req, res_val, res_str, ev, es);
        end
    endtask

    task automatic t_reset();
        clear_all(); sv[0] = V1; ss[0] = 3'd6;
        rst_n = 1'b0;
        apply();
        chk("R2 reset", VZ, 3'd0);
        rst_n = 1'b1;
        apply();
        chk("R2 one-edge latency", V1, 3'd6);
    endtask

    task automatic t_stronger();
        clear_all(); sv[1] = V1; ss[1] = 3'd6; sv[5] = V0; ss[5] = 3'd5;
        apply(); chk("R3 strong1 over pull0", V1, 3'd6);
        clear_all(); sv[2] = V1; ss[2] = 3'd5; sv[7] = V0; ss[7] = 3'd7;
        apply(); chk("R3 supply0 over pull1", V0, 3'd7);
        clear_all(); sv[0] = V0; ss[0] = 3'd1; sv[3] = V1; ss[3] = 3'd2;
        apply(); chk("R1 medium over small ranking", V1, 3'd2);
    endtask

    task automatic t_tie();
        clear_all(); sv[3] = V1; ss[3] = 3'd6; sv[4] = V0; ss[4] = 3'd6;
        apply(); chk("R4 strong tie", VX, 3'd6);
        clear_all(); sv[0] = V1; ss[0] = 3'd5; sv[6] = V0; ss[6] = 3'd5; sv[2] = V1; ss[2] = 3'd4;
        apply(); chk("R4 pull tie over weak", VX, 3'd5);
    endtask

    task automatic t_agree();
        clear_all(); sv[1] = V1; ss[1] = 3'd5; sv[2] = V1; ss[2] = 3'd5;
        apply(); chk("R5 equal agree", V1, 3'd5);
        clear_all(); sv[0] = V0; ss[0] = 3'd2; sv[7] = V0; ss[7] = 3'd6;
        apply(); chk("R5 higher of agreeing", V0, 3'd6);
    endtask

    task automatic t_undriven();
        clear_all();
        apply(); chk("R6 all undriven", VZ, 3'd0);
    endtask

    task automatic t_ignored();
        clear_all();
        for (int i = 0; i < N; i++) sv[i] = (i % 2 == 0) ? V0 : V1;
        sv[4] = V1; ss[4] = 3'd1;
        apply(); chk("R7 rank-0 values ignored", V1, 3'd1);
        clear_all(); sv[2] = VZ; ss[2] = 3'd7; sv[5] = V0; ss[5] = 3'd3;
        apply(); chk("R7 z at supply ignored", V0, 3'd3);
    endtask

    task automatic t_cap_drive();
        clear_all(); sv[0] = V1; ss[0] = 3'd3; sv[1] = V0; ss[1] = 3'd4;
        apply(); chk("R8 weak over large", V0, 3'd4);
        clear_all(); sv[6] = V1; ss[6] = 3'd3; sv[7] = V0; ss[7] = 3'd3;
        apply(); chk("R8 equal cap ranks", VX, 3'd3);
    endtask

    task automatic t_xdrv();
        clear_all(); sv[2] = VX; ss[2] = 3'd5; sv[3] = V1; ss[3] = 3'd5;
        apply(); chk("R9 x ties 1", VX, 3'd5);
        clear_all(); sv[2] = VX; ss[2] = 3'd5; sv[3] = V1; ss[3] = 3'd6;
        apply(); chk("R9 stronger 1 beats x", V1, 3'd6);
        clear_all(); sv[4] = VX; ss[4] = 3'd4; sv[5] = V0; ss[5] = 3'd2;
        apply(); chk("R9 x over weaker 0", VX, 3'd4);
    endtask

    task automatic t_random();
        logic [1:0] tv [N];
        logic [2:0] ts [N];
        logic [4:0] exp;
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < N; i++) begin
                sv[i] = 2'($urandom_range(0, 3));
                ss[i] = 3'($urandom_range(0, 7));
            end
            exp = ref_fold();
            apply(); chk("R10 random set", exp[4:3], exp[2:0]);
            for (int i = 0; i < N; i++) begin
                tv[i] = sv[N-1-i]; ts[i] = ss[N-1-i];
            end
            for (int i = 0; i < N; i++) begin
                sv[i] = tv[i]; ss[i] = ts[i];
            end
            apply(); chk("R10 reversed slots", exp[4:3], exp[2:0]);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

    initial begin
        clear_all();
        drv_val = '1;
        drv_str = '0;
        @(negedge clk);
        t_reset();
        t_stronger();
        t_tie();
        t_agree();
        t_undriven();
        t_ignored();
        t_cap_drive();
        t_xdrv();
        t_random();
        done = 1'b1;
        finish_run();
    end

endmodule